// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost-Empty and Almost-Full Flags

This block is a first-in first-out buffer with independent write and read clocks. Words are 9 bits wide and the depth is a power-of-two parameter (1024 words by default). Alongside the full and empty indications it produces two early-warning flags. The almost-empty flag fires when few words remain to be read. The almost-full flag fires when few locations remain free. Each flag's distance from its hard limit is a run-time offset.

The two offsets (n for almost-empty, m for almost-full) are each split into a low register of 8 bits and a high register that holds the remaining offset bits. A configuration select input turns the ordinary write and read strobes into offset accesses. Each configuration write stores the low bits of the data bus into the next register in a fixed rotation. The rotation is empty-low, empty-high, full-low, full-high, and then back to empty-low. Configuration reads on the read side return the same four registers in the same rotation. Pointers cross clock domains in Gray code. Each flag is evaluated and registered in the clock domain that owns it.

Top module: `prog_flag_fifo`

## Requirements
- R1: While rst_n is low, and after it is released, empty_n and aempty_n are 0 and full_n and afull_n are 1. All four offset registers return to their defaults: each low part is 7 and each high part is 0, so n = m = 7.
- R2: Words written with cfg_n=1 and wr_en_n=0 are returned on rdata in the order they were written. Each word appears one read-clock edge after a read taken with cfg_n=1 and rd_en_n=0.
- R3: empty_n is 0 exactly when no unread words exist. It falls after the read-clock edge of the read that takes the last word. A read attempted while empty changes neither rdata nor the occupancy.
- R4: full_n is 0 when DEPTH words are unread. It falls after the write-clock edge of the write that fills the buffer. A write attempted while full is discarded.
- R5: aempty_n is 0 when the unread count is n or fewer, and 1 when it is n+1 or more.
- R6: afull_n is 0 when the unread count is at least DEPTH minus m, and 1 otherwise.
- R7: A write-clock edge with cfg_n=0 and wr_en_n=0 stores wdata into the next offset register. The rotation runs empty-low, empty-high, full-low, full-high and then wraps to empty-low. The rotation restarts at empty-low on reset.
- R8: With cfg_n=0 and wr_en_n=1 nothing changes: the offset rotation does not advance and no word enters the buffer. Configuration writes never change the buffer's occupancy.
- R9: A read-clock edge with cfg_n=0 and rd_en_n=0 places the next offset register on rdata. It uses the same rotation, with wrap, and the register is zero-extended. High registers keep only AW-8 bits (2 bits at depth 1024), and unused bits read back as zero.
- R10: afull_n and full_n change on the write-clock edge of the write that crosses their threshold. aempty_n and empty_n change on the read-clock edge of the read that crosses theirs. Each passes through a single register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_n | input | 1 | Write strobe, active low |
| rd_en_n | input | 1 | Read strobe, active low |
| cfg_n | input | 1 | Low: strobes access offset registers; high: strobes access the buffer |
| wdata | input | 9 | Write data and offset load value |
| rdata | output | 9 | Read data or offset readback value |
| full_n | output | 1 | Low when the buffer is full |
| empty_n | output | 1 | Low when the buffer is empty |
| afull_n | output | 1 | Low when unread count is at least DEPTH-m |
| aempty_n | output | 1 | Low when unread count is at most n |

## Verification
Suppose a pointer or its Gray image goes wrong. On the side that owns the pointer, the error shows in full_n or empty_n on the very next edge of that clock. On the opposite side it shows about two cycles later, after synchroniser latency, as a wrong occupancy behind aempty_n or afull_n. It also shows as data arriving out of order on rdata.

A wrong offset rotation state is seen at the next configuration readback as a register value in the wrong slot. It is also seen in the flags, which then trip at a shifted word count. Filling the buffer to the brim and draining it exposes wrap-around and overflow damage within one full pass.

// File: rtl/afifo_pkg.sv
`timescale 1ns/1ps
package afifo_pkg;
    localparam int LO_W       = 8;
    localparam int OFF_DEF_LO = 7;

    typedef enum logic [1:0] {
        SEL_E_LO = 2'd0,
        SEL_E_HI = 2'd1,
        SEL_F_LO = 2'd2,
        SEL_F_HI = 2'd3
    } off_sel_e;
endpackage

// File: rtl/afifo_sync2.sv
`timescale 1ns/1ps
module afifo_sync2 #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign dout = sync_q;
endmodule

// File: rtl/afifo_mem.sv
`timescale 1ns/1ps
module afifo_mem #(
    parameter int DEPTH = 1024,
    parameter int DW    = 9,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rword
);
    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rword = store[raddr];
endmodule

// File: rtl/afifo_wr_ctrl.sv
`timescale 1ns/1ps
module afifo_wr_ctrl
    import afifo_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1,
    localparam int HW   = AW - LO_W
) (
    input  logic            wclk,
    input  logic            rst_n,
    input  logic            wr_en_n,
    input  logic            cfg_n,
    input  logic [LO_W-1:0] cfg_data,
    input  logic [PW-1:0]   rgray_s,
    output logic [PW-1:0]   wgray,
    output logic [AW-1:0]   waddr,
    output logic            wr_fire,
    output logic            full_n,
    output logic            afull_n,
    output logic [AW-1:0]   n_off,
    output logic [AW-1:0]   m_off
);
    typedef struct packed {
        logic [PW-1:0]   bin;
        logic [PW-1:0]   gray;
        logic            full_n;
        logic            af_n;
        off_sel_e        sel;
        logic [LO_W-1:0] e_lo;
        logic [HW-1:0]   e_hi;
        logic [LO_W-1:0] f_lo;
        logic [HW-1:0]   f_hi;
    } wst_t;

    wst_t q, d;
    logic [PW-1:0] rbin;
    logic [PW-1:0] cnt_next;
    logic [PW-1:0] cnt_now;
    logic [AW+1:0] af_sum;
    logic          cfg_wr;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    always_comb begin
        rbin    = g2b(rgray_s);
        wr_fire = !wr_en_n && cfg_n && q.full_n;
        cfg_wr  = !wr_en_n && !cfg_n;
        d       = q;
        if (wr_fire) d.bin = q.bin + 1'b1;
        d.gray   = d.bin ^ (d.bin >> 1);
        cnt_next = d.bin - rbin;
        cnt_now  = q.bin - rbin;
        d.full_n = (cnt_next != PW'(DEPTH));
        af_sum   = {1'b0, cnt_next} + (AW+2)'({q.f_hi, q.f_lo});
        d.af_n   = !(af_sum >= (AW+2)'(DEPTH));
        if (cfg_wr) begin
            case (q.sel)
                SEL_E_LO: d.e_lo = cfg_data;
                SEL_E_HI: d.e_hi = cfg_data[HW-1:0];
                SEL_F_LO: d.f_lo = cfg_data;
                default:  d.f_hi = cfg_data[HW-1:0];
            endcase
            d.sel = off_sel_e'(2'(q.sel + 2'd1));
        end
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            q.bin    <= '0;
            q.gray   <= '0;
            q.full_n <= 1'b1;
            q.af_n   <= 1'b1;
            q.sel    <= SEL_E_LO;
            q.e_lo   <= LO_W'(OFF_DEF_LO);
            q.e_hi   <= '0;
            q.f_lo   <= LO_W'(OFF_DEF_LO);
            q.f_hi   <= '0;
        end else begin
            q <= d;
        end
    end

    assign wgray   = q.gray;
    assign waddr   = q.bin[AW-1:0];
    assign full_n  = q.full_n;
    assign afull_n = q.af_n;
    assign n_off   = {q.e_hi, q.e_lo};
    assign m_off   = {q.f_hi, q.f_lo};

    a_r4_no_overflow: assert property (@(posedge wclk) disable iff (!rst_n)
        cnt_now <= PW'(DEPTH));

    a_r10_full_fall: assert property (@(posedge wclk) disable iff (!rst_n)
        $fell(q.full_n) |-> $past(!wr_en_n && cfg_n));

    a_r7_sel_step: assert property (@(posedge wclk) disable iff (!rst_n)
        cfg_wr |=> (q.sel == off_sel_e'(2'($past(q.sel) + 2'd1))));

    a_r8_sel_hold: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_en_n && !cfg_n) |=> $stable(q.sel) && $stable(q.bin));
endmodule

// File: rtl/afifo_rd_ctrl.sv
`timescale 1ns/1ps
module afifo_rd_ctrl
    import afifo_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int DW    = 9,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          rd_en_n,
    input  logic          cfg_n,
    input  logic [PW-1:0] wgray_s,
    input  logic [AW-1:0] n_off,
    input  logic [AW-1:0] m_off,
    input  logic [DW-1:0] mem_word,
    output logic [PW-1:0] rgray,
    output logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    output logic          empty_n,
    output logic          aempty_n
);
    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          empty_n;
        logic          ae_n;
        off_sel_e      sel;
        logic [DW-1:0] rdata;
    } rst_t;

    rst_t q, d;
    logic [PW-1:0] wbin;
    logic [PW-1:0] cnt_next;
    logic [PW-1:0] cnt_now;
    logic          rd_fire;
    logic          cfg_rd;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    always_comb begin
        wbin    = g2b(wgray_s);
        rd_fire = !rd_en_n && cfg_n && q.empty_n;
        cfg_rd  = !rd_en_n && !cfg_n;
        d       = q;
        if (rd_fire) begin
            d.rdata = mem_word;
            d.bin   = q.bin + 1'b1;
        end
        if (cfg_rd) begin
            case (q.sel)
                SEL_E_LO: d.rdata = DW'(n_off[LO_W-1:0]);
                SEL_E_HI: d.rdata = DW'(n_off[AW-1:LO_W]);
                SEL_F_LO: d.rdata = DW'(m_off[LO_W-1:0]);
                default:  d.rdata = DW'(m_off[AW-1:LO_W]);
            endcase
            d.sel = off_sel_e'(2'(q.sel + 2'd1));
        end
        d.gray    = d.bin ^ (d.bin >> 1);
        cnt_next  = wbin - d.bin;
        cnt_now   = wbin - q.bin;
        d.empty_n = (cnt_next != '0);
        d.ae_n    = (cnt_next > PW'(n_off));
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            q.bin     <= '0;
            q.gray    <= '0;
            q.empty_n <= 1'b0;
            q.ae_n    <= 1'b0;
            q.sel     <= SEL_E_LO;
            q.rdata   <= '0;
        end else begin
            q <= d;
        end
    end

    assign rgray    = q.gray;
    assign raddr    = q.bin[AW-1:0];
    assign rdata    = q.rdata;
    assign empty_n  = q.empty_n;
    assign aempty_n = q.ae_n;

    a_r3_no_underflow: assert property (@(posedge rclk) disable iff (!rst_n)
        cnt_now <= PW'(DEPTH));

    a_r3_empty_fall: assert property (@(posedge rclk) disable iff (!rst_n)
        $fell(q.empty_n) |-> $past(!rd_en_n && cfg_n));

    a_r5_ae_when_empty: assert property (@(posedge rclk) disable iff (!rst_n)
        !q.empty_n |-> !q.ae_n);

    a_r3_hold_when_empty: assert property (@(posedge rclk) disable iff (!rst_n)
        (!q.empty_n && cfg_n) |=> $stable(q.rdata) && $stable(q.bin));
endmodule

// File: rtl/prog_flag_fifo.sv
`timescale 1ns/1ps
module prog_flag_fifo #(
    parameter int DEPTH = 1024,
    parameter int DW    = 9,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          wr_en_n,
    input  logic          rd_en_n,
    input  logic          cfg_n,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          full_n,
    output logic          empty_n,
    output logic          afull_n,
    output logic          aempty_n
);
    logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
    logic [AW-1:0] waddr, raddr, n_off, m_off;
    logic          wr_fire;
    logic [DW-1:0] mem_word;

    afifo_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
        .wclk(wclk), .rst_n(rst_n), .wr_en_n(wr_en_n), .cfg_n(cfg_n),
        .cfg_data(wdata[afifo_pkg::LO_W-1:0]), .rgray_s(rgray_s),
        .wgray(wgray), .waddr(waddr), .wr_fire(wr_fire),
        .full_n(full_n), .afull_n(afull_n), .n_off(n_off), .m_off(m_off)
    );

    afifo_sync2 #(.W(PW)) u_sync_r2w (
        .clk(wclk), .rst_n(rst_n), .din(rgray), .dout(rgray_s)
    );

    afifo_sync2 #(.W(PW)) u_sync_w2r (
        .clk(rclk), .rst_n(rst_n), .din(wgray), .dout(wgray_s)
    );

    afifo_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
        .wclk(wclk), .we(wr_fire), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rword(mem_word)
    );

    afifo_rd_ctrl #(.DEPTH(DEPTH), .DW(DW)) u_rd (
        .rclk(rclk), .rst_n(rst_n), .rd_en_n(rd_en_n), .cfg_n(cfg_n),
        .wgray_s(wgray_s), .n_off(n_off), .m_off(m_off), .mem_word(mem_word),
        .rgray(rgray), .raddr(raddr), .rdata(rdata),
        .empty_n(empty_n), .aempty_n(aempty_n)
    );

    a_r4_gray_step_w: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);

    a_r3_gray_step_r: assert property (@(posedge rclk) disable iff (!rst_n)
        $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: tb/tb_prog_flag_fifo.sv
`timescale 1ns/1ps
module tb_prog_flag_fifo;
    localparam int DEPTH = 1024;
    localparam int DW    = 9;

    logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
    logic wr_en_n = 1'b1, rd_en_n = 1'b1, cfg_n = 1'b1;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic full_n, empty_n, afull_n, aempty_n;

    int checks = 0;
    int errors = 0;

    prog_flag_fifo #(.DEPTH(DEPTH), .DW(DW)) dut (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en_n(wr_en_n),
        .rd_en_n(rd_en_n), .cfg_n(cfg_n), .wdata(wdata), .rdata(rdata),
        .full_n(full_n), .empty_n(empty_n), .afull_n(afull_n), .aempty_n(aempty_n)
    );

    always #2.5 wclk = ~wclk;
    initial begin
        #1.3;
        forever #2.5 rclk = ~rclk;
    end

    // op: 0 cfg write, 1 buffer write, 2 cfg read (check), 3 buffer read (check)
    typedef struct packed {
        logic [1:0]    op;
        logic [DW-1:0] val;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 9'h003}, '{2'd0, 9'h000}, '{2'd0, 9'h005}, '{2'd0, 9'h000},
        '{2'd2, 9'h003}, '{2'd2, 9'h000}, '{2'd2, 9'h005}, '{2'd2, 9'h000},
        '{2'd2, 9'h003},
        '{2'd1, 9'h1A5}, '{2'd1, 9'h05A}, '{2'd1, 9'h100},
        '{2'd3, 9'h1A5}, '{2'd3, 9'h05A}, '{2'd3, 9'h100}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en_n = 1'b1; rd_en_n = 1'b1; cfg_n = 1'b1;
        #20;
        rst_n = 1'b1;
        #20;
    endtask

    task automatic wr_word(input logic [DW-1:0] v);
        @(negedge wclk);
        cfg_n = 1'b1; wr_en_n = 1'b0; wdata = v;
        @(negedge wclk);
        wr_en_n = 1'b1;
    endtask

    task automatic wr_cfg(input logic [DW-1:0] v);
        @(negedge wclk);
        cfg_n = 1'b0; wr_en_n = 1'b0; wdata = v;
        @(negedge wclk);
        wr_en_n = 1'b1; cfg_n = 1'b1;
    endtask

    task automatic rd_word(output logic [DW-1:0] v);
        @(negedge rclk);
        cfg_n = 1'b1; rd_en_n = 1'b0;
        @(negedge rclk);
        rd_en_n = 1'b1;
        v = rdata;
    endtask

    task automatic rd_cfg(output logic [DW-1:0] v);
        @(negedge rclk);
        cfg_n = 1'b0; rd_en_n = 1'b0;
        @(negedge rclk);
        rd_en_n = 1'b1; cfg_n = 1'b1;
        v = rdata;
    endtask

    task automatic settle();
        #60;
    endtask

    function automatic logic [DW-1:0] pat(input int i);
        return DW'((i * 37 + 11) % 512);
    endfunction

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] got;

        // R1: state during and after reset
        #10;
        chk("R1 empty_n in reset", 32'(empty_n), 0);
        chk("R1 full_n in reset", 32'(full_n), 1);
        do_reset();
        chk("R1 empty_n", 32'(empty_n), 0);
        chk("R1 aempty_n", 32'(aempty_n), 0);
        chk("R1 full_n", 32'(full_n), 1);
        chk("R1 afull_n", 32'(afull_n), 1);
        rd_cfg(got); chk("R1 default empty-low", 32'(got), 7);
        rd_cfg(got); chk("R1 default empty-high", 32'(got), 0);
        rd_cfg(got); chk("R1 default full-low", 32'(got), 7);
        rd_cfg(got); chk("R1 default full-high", 32'(got), 0);

        // Table walk: R7 load order, R9 readback with wrap, R2 order
        do_reset();
        for (int k = 0; k < NV; k++) begin
            case (VEC[k].op)
                2'd0: wr_cfg(VEC[k].val);
                2'd1: begin wr_word(VEC[k].val); settle(); end
                2'd2: begin rd_cfg(got); chk("R9/R7 readback", 32'(got), 32'(VEC[k].val)); end
                default: begin rd_word(got); chk("R2 order", 32'(got), 32'(VEC[k].val)); end
            endcase
        end

        // R3: empty behaviour
        do_reset();
        rd_word(got);
        chk("R3 read while empty keeps rdata", 32'(got), 0);
        chk("R3 still empty", 32'(empty_n), 0);
        wr_word(9'h0AA); settle();
        chk("R3 empty_n high with one word", 32'(empty_n), 1);
        rd_word(got);
        chk("R3 single word", 32'(got), 32'h0AA);
        chk("R3 empty_n falls after last read", 32'(empty_n), 0);
        rd_word(got);
        chk("R3 read while empty ignored", 32'(got), 32'h0AA);
        wr_word(9'h055); settle();
        rd_word(got);
        chk("R3 pointer intact", 32'(got), 32'h055);

        // R5/R6/R4/R10 with default offsets n = m = 7
        do_reset();
        for (int i = 0; i < 7; i++) wr_word(pat(i));
        settle();
        chk("R5 aempty_n low at n words", 32'(aempty_n), 0);
        wr_word(pat(7)); settle();
        chk("R5 aempty_n high at n+1 words", 32'(aempty_n), 1);
        for (int i = 8; i < DEPTH - 8; i++) wr_word(pat(i));
        settle();
        chk("R6 afull_n high at DEPTH-8", 32'(afull_n), 1);
        wr_word(pat(DEPTH - 8));
        chk("R10 afull_n low right after crossing write", 32'(afull_n), 0);
        for (int i = DEPTH - 7; i < DEPTH - 1; i++) wr_word(pat(i));
        settle();
        chk("R4 full_n high at DEPTH-1", 32'(full_n), 1);
        wr_word(pat(DEPTH - 1));
        chk("R4 full_n low right after filling write", 32'(full_n), 0);
        wr_word(9'h1FF);
        settle();
        for (int i = 0; i < DEPTH; i++) begin
            rd_word(got);
            chk("R2 drain order", 32'(got), 32'(pat(i)));
            if (i == DEPTH - 8)
                chk("R10 aempty_n low right after read to n", 32'(aempty_n), 0);
        end
        chk("R4 write while full discarded", 32'(empty_n), 0);
        settle();
        chk("R4 full_n released", 32'(full_n), 1);
        chk("R6 afull_n released", 32'(afull_n), 1);

        // R8 no-op, R9 high bits, programmed R5/R6 (n = 300, m = 512)
        do_reset();
        @(negedge wclk); cfg_n = 1'b0; wdata = 9'h1EE;
        @(negedge wclk); @(negedge wclk); cfg_n = 1'b1;
        wr_cfg(9'h02C);
        wr_cfg(9'h1FD);
        wr_cfg(9'h000);
        wr_cfg(9'h002);
        settle();
        chk("R8 cfg writes leave buffer empty", 32'(empty_n), 0);
        rd_cfg(got); chk("R8 no-op did not advance rotation", 32'(got), 32'h02C);
        rd_cfg(got); chk("R9 high part truncated", 32'(got), 32'h001);
        rd_cfg(got); chk("R9 full-low", 32'(got), 32'h000);
        rd_cfg(got); chk("R9 full-high", 32'(got), 32'h002);
        for (int i = 0; i < 300; i++) wr_word(pat(i));
        settle();
        chk("R5 programmed n: low at 300", 32'(aempty_n), 0);
        wr_word(pat(300)); settle();
        chk("R5 programmed n: high at 301", 32'(aempty_n), 1);
        for (int i = 301; i < 511; i++) wr_word(pat(i));
        settle();
        chk("R6 programmed m: high at 511", 32'(afull_n), 1);
        wr_word(pat(511));
        chk("R6 programmed m: low at 512", 32'(afull_n), 0);
        rd_word(got);
        chk("R2 first word after config", 32'(got), 32'(pat(0)));
        settle();
        chk("R6 programmed m: high again at 511", 32'(afull_n), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule